// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This block keeps the status state of a serial nonvolatile memory slave: a busy flag, a write-enable latch, two block-protect bits and a bit that arms the hardware guard pin. It takes opcodes and data bytes already deserialised by a neighbouring shifter. It executes the set-latch, clear-latch and load-status commands. It works out, for any 17-bit array address and for the status register itself, whether a write is allowed at this moment. It also forms the byte returned when the status register is read.

The guard-enable bit and the two block-protect bits model nonvolatile cells. A load-status command only stages a byte. The byte reaches those bits after a timed program cycle of `PROG_CYCLES` clocks, which begins when the frame closes. While any internal cycle runs, either this block's own or the array's (signalled on `array_busy_i`), the status byte reads all ones and the latch commands are ignored. The page write path asks `addr_locked_o` and `addr_writable_o` about the address it is about to program.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset with default parameters, `status_o` is 0x00, `addr_locked_o` is 0 for every address, and both `addr_writable_o` and `status_writable_o` are 0.
- R2: An opcode is decoded with bit 3 ignored. 0x06 (or 0x0E) sets the write-enable latch and 0x04 (or 0x0C) clears it, from the clock edge after `op_valid_i`. The clear works whatever the level of `guard_n`.
- R3: When idle, `status_o` reads {guard-enable, 3'b000, bp1, bp0, write-enable, 1'b0}: bit 7 is guard-enable, bits 3:2 are the protect level, bit 1 is the latch and bit 0 is 0. Bits 6:4 of a loaded byte are dropped. During any internal cycle `status_o` reads 0xFF.
- R4: `addr_locked_o` follows the protect level: 00 locks nothing, 01 locks 0x18000–0x1FFFF, 10 locks 0x10000–0x1FFFF and 11 locks every address.
- R5: `addr_writable_o` is 1 only when the latch is set and the address is not locked. `status_writable_o` is 1 only when the latch is set and the hardware guard is not active.
- R6: Opcode 0x01 followed by a data byte and a frame end starts a program cycle. For exactly `PROG_CYCLES` clocks after the frame-end edge `status_o` reads 0xFF. Then bits 7, 3 and 2 of the byte take effect and the latch is clear.
- R7: A load-status frame issued while the latch is clear starts no cycle and changes no status bit.
- R8: The hardware guard is active when `guard_n` is 0 and guard-enable is 1. While it is active a load-status frame is ignored, so guard-enable cannot be cleared.
- R9: If the guard becomes active at any point before the frame end of a load-status frame, that load is abandoned. Once the program cycle has started, changing `guard_n` has no effect on it.
- R10: While `array_busy_i` is 1, latch commands are ignored.
- R11: A pulse on `page_done_i` clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| guard_n | input | 1 | Hardware guard pin, active low |
| frame_active_i | input | 1 | Slave selected, frame in progress |
| frame_end_i | input | 1 | One-cycle pulse when the frame closes |
| op_valid_i | input | 1 | Opcode byte strobe |
| op_code_i | input | 8 | Received opcode |
| data_valid_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Received data byte |
| array_busy_i | input | 1 | Array program cycle in progress |
| page_done_i | input | 1 | Array program cycle completed |
| addr_i | input | ADDR_W | Array address to evaluate |
| status_o | output | 8 | Status byte for a status read |
| addr_locked_o | output | 1 | Address lies in a protected block |
| addr_writable_o | output | 1 | Address may be programmed now |
| status_writable_o | output | 1 | Status register may be loaded now |

## Verification
The assertions assume the neighbour strobes at most one of opcode, data and frame end per cycle. They also assume opcodes arrive only while a frame is active, and that `page_done_i` comes only while no status cycle runs. The directed stimulus drives each strobe for a single cycle at the falling clock edge. It keeps `array_busy_i` and `page_done_i` apart from its own load-status frames, so each check sees one source of change at a time.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int OPC_W = 8;
   localparam logic [OPC_W-1:0] OPC_MASK  = 8'hF7;
   localparam logic [OPC_W-1:0] OPC_SETWL = 8'h06;
   localparam logic [OPC_W-1:0] OPC_CLRWL = 8'h04;
   localparam logic [OPC_W-1:0] OPC_LDSR  = 8'h01;

   typedef struct packed {
      logic       guard_en;
      logic [1:0] level;
   } nv_bits_t;

   function automatic logic opc_is(input logic [OPC_W-1:0] code,
                                   input logic [OPC_W-1:0] ref_code);
      return (code & OPC_MASK) == ref_code;
   endfunction
endpackage

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode
   import sr_pkg::*;
(
   input  logic             valid_i,
   input  logic [OPC_W-1:0] code_i,
   input  logic             busy_i,
   output logic             set_wl_o,
   output logic             clr_wl_o,
   output logic             load_o
);
   logic take;
   always_comb begin
      take     = valid_i && !busy_i;
      set_wl_o = take && opc_is(code_i, OPC_SETWL);
      clr_wl_o = take && opc_is(code_i, OPC_CLRWL);
      load_o   = take && opc_is(code_i, OPC_LDSR);
   end
endmodule

// File: rtl/sr_prog_timer.sv
module sr_prog_timer #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= LOAD;
         end
      end else if (cnt_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/sr_protect_eval.sv
module sr_protect_eval #(
   parameter int ADDR_W = 17
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        level_i,
   output logic              locked_o
);
   logic [1:0] quarter;
   generate
      if (ADDR_W >= 2) begin : g_quarter
         assign quarter = addr_i[ADDR_W-1 -: 2];
      end else begin : g_bad
         $error("ADDR_W must be at least 2");
         assign quarter = 2'b00;
      end
   endgenerate

   always_comb begin
      unique case (level_i)
         2'b00:   locked_o = 1'b0;
         2'b01:   locked_o = (quarter == 2'b11);
         2'b10:   locked_o = quarter[1];
         default: locked_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
   import sr_pkg::*;
#(
   parameter int         ADDR_W      = 17,
   parameter int         PROG_CYCLES = 8,
   parameter logic       INIT_GUARD  = 1'b0,
   parameter logic [1:0] INIT_LEVEL  = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              guard_n,
   input  logic              frame_active_i,
   input  logic              frame_end_i,
   input  logic              op_valid_i,
   input  logic [7:0]        op_code_i,
   input  logic              data_valid_i,
   input  logic [7:0]        data_i,
   input  logic              array_busy_i,
   input  logic              page_done_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [7:0]        status_o,
   output logic              addr_locked_o,
   output logic              addr_writable_o,
   output logic              status_writable_o
);
   generate
      if (PROG_CYCLES < 1) begin : g_bad_cycles
         $error("PROG_CYCLES must be at least 1");
      end
   endgenerate

   nv_bits_t nv_q, staged_q;
   logic     wen_q, armed_q, got_q;
   logic     prog_busy, prog_done, busy, hw_lock;
   logic     set_wl, clr_wl, load_req, start;

   assign busy    = prog_busy || array_busy_i;
   assign hw_lock = !guard_n && nv_q.guard_en;

   sr_cmd_decode dec_i (
      .valid_i (op_valid_i && frame_active_i),
      .code_i  (op_code_i),
      .busy_i  (busy),
      .set_wl_o(set_wl),
      .clr_wl_o(clr_wl),
      .load_o  (load_req)
   );

   assign start = frame_end_i && armed_q && got_q && !hw_lock && wen_q && !busy;

   sr_prog_timer #(.CYCLES(PROG_CYCLES)) tmr_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start),
      .busy_o (prog_busy),
      .done_o (prog_done)
   );

   sr_protect_eval #(.ADDR_W(ADDR_W)) prot_i (
      .addr_i  (addr_i),
      .level_i (nv_q.level),
      .locked_o(addr_locked_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q <= 1'b0;
      end else if (prog_done || page_done_i) begin
         wen_q <= 1'b0;
      end else if (set_wl) begin
         wen_q <= 1'b1;
      end else if (clr_wl) begin
         wen_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         got_q    <= 1'b0;
         staged_q <= '0;
      end else if (frame_end_i || hw_lock) begin
         armed_q <= 1'b0;
         got_q   <= 1'b0;
      end else if (load_req && wen_q) begin
         armed_q <= 1'b1;
         got_q   <= 1'b0;
      end else if (armed_q && data_valid_i && !got_q) begin
         got_q    <= 1'b1;
         staged_q <= '{guard_en: data_i[7], level: data_i[3:2]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nv_q <= '{guard_en: INIT_GUARD, level: INIT_LEVEL};
      end else if (prog_done) begin
         nv_q <= staged_q;
      end
   end

   assign status_o          = busy ? 8'hFF
                                   : {nv_q.guard_en, 3'b000, nv_q.level, wen_q, 1'b0};
   assign addr_writable_o   = wen_q && !addr_locked_o;
   assign status_writable_o = wen_q && !hw_lock;
endmodule

// File: rtl/sr_wp_unit_chk.sv
module sr_wp_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       guard_n,
   input logic       frame_active_i,
   input logic       op_valid_i,
   input logic [7:0] op_code_i,
   input logic       array_busy_i,
   input logic       page_done_i,
   input logic [7:0] status_o,
   input logic       addr_locked_o,
   input logic       addr_writable_o,
   input logic       status_writable_o,
   input logic       wen,
   input logic       prog_busy,
   input logic       prog_done,
   input logic [2:0] nv_bits
);
   logic idle;
   assign idle = !prog_busy && !array_busy_i;

   assert_set_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && frame_active_i && ((op_code_i & 8'hF7) == 8'h06) && idle && !page_done_i)
      |=> wen);

   assert_clear_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && frame_active_i && ((op_code_i & 8'hF7) == 8'h04) && idle)
      |=> !wen);

   assert_busy_all_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy || array_busy_i) |-> (status_o == 8'hFF));

   assert_writable_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_writable_o |-> (wen && !addr_locked_o));

   assert_commit_clears_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_busy) |-> !wen);

   assert_nv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_done |=> $stable(nv_bits));

   assert_guard_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!guard_n && status_o[7] && idle) |-> !status_writable_o);

   assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_busy && !prog_done && !page_done_i) |=> $stable(wen));
endmodule

bind sr_wp_unit sr_wp_unit_chk chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .guard_n          (guard_n),
   .frame_active_i   (frame_active_i),
   .op_valid_i       (op_valid_i),
   .op_code_i        (op_code_i),
   .array_busy_i     (array_busy_i),
   .page_done_i      (page_done_i),
   .status_o         (status_o),
   .addr_locked_o    (addr_locked_o),
   .addr_writable_o  (addr_writable_o),
   .status_writable_o(status_writable_o),
   .wen              (wen_q),
   .prog_busy        (prog_busy),
   .prog_done        (prog_done),
   .nv_bits          (nv_q)
);

// File: tb/sr_wp_unit_tb_top.sv
module sr_wp_unit_tb_top;
   localparam int AW   = 17;
   localparam int PROG = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          guard_n = 1'b1;
   logic          frame_active = 1'b0, frame_end = 1'b0;
   logic          op_valid = 1'b0, data_valid = 1'b0;
   logic [7:0]    op_code = '0, data = '0;
   logic          array_busy = 1'b0, page_done = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    status;
   logic          locked, writable, sr_writable;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   sr_wp_unit #(.ADDR_W(AW), .PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .guard_n(guard_n),
      .frame_active_i(frame_active), .frame_end_i(frame_end),
      .op_valid_i(op_valid), .op_code_i(op_code),
      .data_valid_i(data_valid), .data_i(data),
      .array_busy_i(array_busy), .page_done_i(page_done),
      .addr_i(addr), .status_o(status), .addr_locked_o(locked),
      .addr_writable_o(writable), .status_writable_o(sr_writable)
   );

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic issue_op(input logic [7:0] op);
      frame_active = 1'b1; op_valid = 1'b1; op_code = op;
      tick();
      op_valid = 1'b0;
   endtask

   task automatic close_frame();
      frame_end = 1'b1; frame_active = 1'b0;
      tick();
      frame_end = 1'b0;
   endtask

   task automatic single(input logic [7:0] op);
      issue_op(op);
      close_frame();
   endtask

   task automatic load_frame(input logic [7:0] b);
      issue_op(8'h01);
      data_valid = 1'b1; data = b;
      tick();
      data_valid = 1'b0;
      close_frame();
   endtask

   task automatic lock_at(input string req, input logic [AW-1:0] a, input bit exp);
      addr = a; #1;
      check(req, locked, exp);
   endtask

   // Full program cycle: 0xFF for PROG clocks, then the new value.
   task automatic program_sr(input logic [7:0] b, input logic [7:0] exp_after);
      single(8'h06);
      load_frame(b);
      check("R6 busy first", status, 8'hFF);
      repeat (PROG - 1) tick();
      check("R6 busy last", status, 8'hFF);
      tick();
      check("R6 after commit", status, exp_after);
   endtask

   task automatic t_reset();
      check("R1 status", status, 8'h00);
      lock_at("R1 lock", 17'h1FFFF, 1'b0);
      check("R1 writable", writable, 0);
      check("R1 sr writable", sr_writable, 0);
   endtask

   task automatic t_latch();
      single(8'h06);
      check("R2 set", status, 8'h02);
      check("R5 sr writable", sr_writable, 1);
      guard_n = 1'b0;
      single(8'h04);
      check("R2 clear with guard low", status, 8'h00);
      guard_n = 1'b1;
      single(8'h0E);
      check("R2 alias set", status, 8'h02);
      single(8'h0C);
      check("R2 alias clear", status, 8'h00);
   endtask

   task automatic t_no_latch();
      load_frame(8'h8C);
      check("R7 no cycle", status, 8'h00);
      tick();
      check("R7 unchanged", status, 8'h00);
   endtask

   task automatic t_levels();
      program_sr(8'h04, 8'h04);
      lock_at("R4 l1 low", 17'h17FFF, 1'b0);
      lock_at("R4 l1 high", 17'h18000, 1'b1);
      check("R5 no latch", writable, 0);
      single(8'h06);
      lock_at("R5 free", 17'h17FFF, 1'b0);
      check("R5 writable free", writable, 1);
      lock_at("R5 locked", 17'h18000, 1'b1);
      check("R5 writable locked", writable, 0);
      program_sr(8'h78, 8'h08);   // R3: bits 6:4 dropped
      lock_at("R4 l2 low", 17'h0FFFF, 1'b0);
      lock_at("R4 l2 high", 17'h10000, 1'b1);
      program_sr(8'h0C, 8'h0C);
      lock_at("R4 l3 zero", 17'h00000, 1'b1);
      program_sr(8'h80, 8'h80);
      lock_at("R4 l0", 17'h1FFFF, 1'b0);
   endtask

   task automatic t_guard();
      guard_n = 1'b0;
      single(8'h06);
      check("R8 latch set", status, 8'h82);
      check("R8 sr locked", sr_writable, 0);
      load_frame(8'h00);
      check("R8 ignored", status, 8'h82);
      guard_n = 1'b1;
   endtask

   task automatic t_abort();
      issue_op(8'h01);
      data_valid = 1'b1; data = 8'h00;
      tick();
      data_valid = 1'b0;
      guard_n = 1'b0;
      tick();
      guard_n = 1'b1;
      close_frame();
      check("R9 aborted", status, 8'h82);
      load_frame(8'h00);
      check("R9 started", status, 8'hFF);
      guard_n = 1'b0;
      repeat (PROG) tick();
      check("R9 commit regardless", status, 8'h00);
      guard_n = 1'b1;
   endtask

   task automatic t_array_busy();
      array_busy = 1'b1;
      tick();
      check("R10 busy ones", status, 8'hFF);
      single(8'h06);
      array_busy = 1'b0;
      tick();
      check("R10 ignored", status, 8'h00);
   endtask

   task automatic t_page_done();
      single(8'h06);
      check("R11 set", status, 8'h02);
      page_done = 1'b1;
      tick();
      page_done = 1'b0;
      check("R11 cleared", status, 8'h00);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_latch();
      t_no_latch();
      t_levels();
      t_guard();
      t_abort();
      t_array_busy();
      t_page_done();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule